// File: doc/BRIEF.md
# Shift-Left Read-Modify-Write Execution Unit

This unit carries out a one-position left shift (or, on request, a left rotate through carry) of an 8-bit operand. The operand is the accumulator or a byte in memory reached over a simple synchronous byte bus. A controller pulses `start` with the mode, rotate select, operand address, program counter, current accumulator and current status byte. The unit then runs its bus cycles, raises `done` for one cycle and presents the new accumulator and status values.

In accumulator mode the unit makes one throwaway read at the program counter and then replaces the accumulator. In memory mode it makes three bus cycles: a read of the operand, a write of that same unchanged byte, and a write of the shifted byte, all to one address. The bus has no back-pressure. Each access takes exactly one clock, and read data is valid on `bus_rdata` in the cycle after `bus_re` is high. Control and status pins are plain levels or pulses.

Top module: `rmw_shift_unit`

## Requirements
- R1: With rotate off, the result is the operand moved one bit toward the MSB, with a zero entering bit 0.
- R2: Carry (status bit 0) takes the operand's bit 7 from before the shift. Any operand with bit 7 set gives carry 1, including 0x80, which gives result 0x00 with carry 1.
- R3: Negative (status bit 7) equals result bit 7, and zero (status bit 1) is 1 exactly when the result is 0x00.
- R4: Status bits other than carry, zero and negative come out equal to the status byte given at start.
- R5: In accumulator mode there is exactly one bus cycle, a read (`bus_re`=1, `bus_we`=0) at the program counter. In the following cycle `acc_out` holds the result. `bus_we` is never high in this mode.
- R6: In memory mode the bus shows a read at the operand address, then a write of the byte read, then a write of the shifted byte, all at that address. `bus_we` is high only in those two write cycles.
- R7: With rotate on, bit 0 of the result takes the carry bit of the status byte given at start.
- R8: `busy` is high during every bus cycle of an operation. `done` is high for exactly one cycle, the cycle after the last access, with `busy` low.
- R9: `start` has no effect while `busy` is high.
- R10: In memory mode `acc_out` at `done` equals the accumulator value given at start.
- R11: After reset `busy`, `done`, `bus_re`, `bus_we`, `acc_out` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when not busy |
| use_mem | input | 1 | 1 = memory operand, 0 = accumulator |
| rotate | input | 1 | 1 = carry enters bit 0, 0 = zero enters bit 0 |
| opnd_addr | input | ADDR_W | Memory operand address |
| pc | input | ADDR_W | Program counter, used for the throwaway read |
| acc_in | input | DATA_W | Current accumulator |
| flags_in | input | DATA_W | Current status byte |
| bus_rdata | input | DATA_W | Read data, valid the cycle after a read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | DATA_W | New accumulator value |
| flags_out | output | DATA_W | New status byte |

## Verification
The bench builds the unit with DATA_W=8 and ADDR_W=8, and keeps the flag positions at carry 0, zero 1 and negative 7. At this size it can sweep every one of the 256 operand values through both modes, both rotate settings and both incoming carries, checking each bus cycle as well as the final accumulator and status. A start pulse injected in the middle of a memory operation checks that the sequence goes on undisturbed.

// File: rtl/rmw_shift_pkg.sv
package rmw_shift_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DUMMY    = 3'd1,
    ST_RD       = 3'd2,
    ST_WR_ORIG  = 3'd3,
    ST_WR_SHIFT = 3'd4
  } rmw_state_e;
endpackage

// File: rtl/rmw_shift_alu.sv
module rmw_shift_alu #(
  parameter int DATA_W = 8,
  parameter int C_BIT  = 0,
  parameter int Z_BIT  = 1,
  parameter int N_BIT  = 7
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] flags_in,
  input  logic              rotate,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flags_new
);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic fill_bit;
  logic carry_out;

  assign fill_bit  = rotate & flags_in[C_BIT];
  assign result    = {opnd[DATA_W-2:0], fill_bit};
  // masked test is "nonzero", not "equal to one"
  assign carry_out = (opnd & MSB_MASK) != '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flag
    if (i == C_BIT) begin : g_c
      assign flags_new[i] = carry_out;
    end else if (i == Z_BIT) begin : g_z
      assign flags_new[i] = (result == '0);
    end else if (i == N_BIT) begin : g_n
      assign flags_new[i] = result[DATA_W-1];
    end else begin : g_pass
      assign flags_new[i] = flags_in[i];
    end
  end
endmodule

// File: rtl/rmw_shift_seq.sv
module rmw_shift_seq
  import rmw_shift_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       use_mem,
  output rmw_state_e state,
  output logic       accept,
  output logic       last,
  output logic       done
);
  rmw_state_e nxt;

  assign accept = start && (state == ST_IDLE);
  assign last   = (state == ST_DUMMY) || (state == ST_WR_SHIFT);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     if (accept) nxt = use_mem ? ST_RD : ST_DUMMY;
      ST_DUMMY:    nxt = ST_IDLE;
      ST_RD:       nxt = ST_WR_ORIG;
      ST_WR_ORIG:  nxt = ST_WR_SHIFT;
      ST_WR_SHIFT: nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= last;
    end
  end
endmodule

// File: rtl/rmw_shift_unit.sv
module rmw_shift_unit
  import rmw_shift_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int C_BIT  = 0,
  parameter int Z_BIT  = 1,
  parameter int N_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_mem,
  input  logic              rotate,
  input  logic [ADDR_W-1:0] opnd_addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] acc_out,
  output logic [DATA_W-1:0] flags_out
);
  rmw_state_e        state;
  logic              accept;
  logic              last;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] flg_q;
  logic [DATA_W-1:0] data_q;
  logic              mem_q;
  logic              rot_q;
  logic [DATA_W-1:0] alu_opnd;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] alu_flags;

  rmw_shift_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .use_mem(use_mem),
    .state  (state),
    .accept (accept),
    .last   (last),
    .done   (done)
  );

  assign alu_opnd = mem_q ? data_q : acc_q;

  rmw_shift_alu #(
    .DATA_W(DATA_W), .C_BIT(C_BIT), .Z_BIT(Z_BIT), .N_BIT(N_BIT)
  ) u_alu (
    .opnd     (alu_opnd),
    .flags_in (flg_q),
    .rotate   (rot_q),
    .result   (alu_res),
    .flags_new(alu_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pc_q   <= '0;
      acc_q  <= '0;
      flg_q  <= '0;
      mem_q  <= 1'b0;
      rot_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= opnd_addr;
      pc_q   <= pc;
      acc_q  <= acc_in;
      flg_q  <= flags_in;
      mem_q  <= use_mem;
      rot_q  <= rotate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (state == ST_WR_ORIG) begin
      data_q <= bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out   <= '0;
      flags_out <= '0;
    end else if (last) begin
      acc_out   <= mem_q ? acc_q : alu_res;
      flags_out <= alu_flags;
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    case (state)
      ST_DUMMY: begin
        bus_addr = pc_q;
        bus_re   = 1'b1;
      end
      ST_RD: begin
        bus_addr = addr_q;
        bus_re   = 1'b1;
      end
      ST_WR_ORIG: begin
        bus_addr  = addr_q;
        bus_wdata = bus_rdata;
        bus_we    = 1'b1;
      end
      ST_WR_SHIFT: begin
        bus_addr  = addr_q;
        bus_wdata = alu_res;
        bus_we    = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/rmw_shift_chk.sv
module rmw_shift_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic              busy,
  input logic              done
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re || bus_we) |-> busy);

  a_r6_rd_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && bus_we));

  a_r6_first_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && busy) |=> (bus_we || !busy || bus_re) );

  a_r6_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_re)) |=> (bus_we && $stable(bus_addr)));

  a_r6_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_re)) |-> (bus_addr == $past(bus_addr)));

  a_r8_done_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_re || bus_we));
endmodule

bind rmw_shift_unit rmw_shift_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_addr(bus_addr),
  .bus_we  (bus_we),
  .bus_re  (bus_re),
  .busy    (busy),
  .done    (done)
);

// File: tb/sim_rmw_shift_unit.sv
`timescale 1ns/1ps
module sim_rmw_shift_unit;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          use_mem = 1'b0;
  logic          rotate = 1'b0;
  logic [AW-1:0] opnd_addr = '0;
  logic [AW-1:0] pc = '0;
  logic [DW-1:0] acc_in = '0;
  logic [DW-1:0] flags_in = '0;
  logic [DW-1:0] bus_rdata = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_we;
  logic          bus_re;
  logic          busy;
  logic          done;
  logic [DW-1:0] acc_out;
  logic [DW-1:0] flags_out;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rmw_shift_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .use_mem(use_mem), .rotate(rotate),
    .opnd_addr(opnd_addr), .pc(pc), .acc_in(acc_in), .flags_in(flags_in),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .busy(busy), .done(done),
    .acc_out(acc_out), .flags_out(flags_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one operation; checks every bus cycle and the result
  task automatic run_op(input bit mem, input bit rot, input bit cin, input logic [7:0] v,
                        input bit poke_start);
    logic [7:0] res, fl, efl, acc0;
    logic [7:0] a, p;
    acc0 = mem ? (v ^ 8'h3C) : v;
    fl   = (v ^ 8'h5A);
    fl[0] = cin;
    a = v + 8'h11;
    p = ~v;
    res = {v[6:0], rot & cin};
    efl = fl;
    efl[0] = v[7];
    efl[1] = (res == 8'h00);
    efl[7] = res[7];

    @(negedge clk);
    start = 1; use_mem = mem; rotate = rot; opnd_addr = a; pc = p;
    acc_in = acc0; flags_in = fl;
    @(negedge clk);
    start = 0;
    acc_in = 8'hEE; flags_in = 8'h00; // later changes must not matter
    if (!mem) begin
      #1;
      chk("R5 dummy read strobe", {bus_re, bus_we, busy}, 3'b101);
      chk("R5 dummy read address", bus_addr, p);
      @(negedge clk); #1;
      chk("R8 done pulse", {done, busy}, 2'b10);
      chk("R1/R7 accumulator result", acc_out, res);
      chk("R2/R3/R4 flags", flags_out, efl);
    end else begin
      #1;
      chk("R6 read cycle", {bus_re, bus_we, busy}, 3'b101);
      chk("R6 read address", bus_addr, a);
      if (poke_start) begin
        start = 1; use_mem = 0; // R9: must be ignored
      end
      @(negedge clk);
      start = 0;
      bus_rdata = v;
      #1;
      chk("R6 write original strobe", {bus_re, bus_we}, 2'b01);
      chk("R6 write original address", bus_addr, a);
      chk("R6 write original data", bus_wdata, v);
      @(negedge clk);
      bus_rdata = 8'hA5;
      #1;
      chk("R6 write shifted strobe", {bus_re, bus_we}, 2'b01);
      chk("R6 write shifted address", bus_addr, a);
      chk("R1/R7 memory result", bus_wdata, res);
      @(negedge clk); #1;
      chk("R8 done pulse", {done, busy}, 2'b10);
      chk("R10 accumulator kept", acc_out, acc0);
      chk("R2/R3/R4 flags", flags_out, efl);
    end
    @(negedge clk); #1;
    chk("R8 done single cycle", {done, busy, bus_we, bus_re}, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset outputs", {busy, done, bus_re, bus_we}, 4'b0000);
    chk("R11 reset acc/flags", {acc_out, flags_out}, 16'h0000);
    rst_n = 1;
    // R2 specific corner: 0x80 -> 0x00, carry 1, zero 1
    run_op(0, 0, 0, 8'h80, 0);
    chk("R2 0x80 corner", flags_out & 8'h83, 8'h03);
    // 0xAC -> 0x58 carry 1
    run_op(1, 0, 0, 8'hAC, 0);
    chk("R1 0xAC corner", flags_out[0], 1'b1);
    // R9: start pulse during a memory operation
    run_op(1, 1, 1, 8'h41, 1);
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 2; c++)
          for (int v = 0; v < 256; v++)
            run_op(m[0], r[0], c[0], v[7:0], 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule